// File: doc/BRIEF.md
# Token-Passing Sparsified Pixel Readout

This block is the digital back end of a 16 by 16 pixel matrix that alternates between two phases. While the phase input is low (detection), every pixel latches at most one hit from its discriminator line together with the timestamp value present on the shared timestamp input. No serial activity takes place in this phase.

When the phase input goes high (readout), a token starts at pixel 0 and travels along a chain in pixel index order, where index = row * 16 + column. Pixels without a pending hit forward the token in the same cycle, so empty pixels cost no time. The first pixel with a pending hit keeps the token and places its column, row and timestamp on the shared bus. The serializer shifts that word out on one line with a frame strobe. When the word is complete, the pixel is marked as read and the token moves on. Once the token leaves the last pixel and the serializer is idle, a done flag rises. Pixel capture runs on the cell clock. Token handling and serialization run on the readout clock.

Top module: `token_pixel_readout`

## Requirements
- R1: A readout emits exactly one word for each pixel that holds a hit, in ascending pixel index order (index = row * 16 + column), and nothing for pixels without a hit.
- R2: Each word is 13 bits, {column[3:0], row[3:0], stamp[4:0]}, sent MSB first on `ser_data`. `ser_frame` is high for exactly 13 consecutive readout clock cycles per word.
- R3: A captured hit stores the value of `stamp_in` present at the cell clock edge that samples the hit.
- R4: A further hit on a pixel that already holds a hit is ignored, and the first stamp is kept.
- R5: At most one pixel holds the token at any time.
- R6: A pixel keeps the token until its whole word has been shifted out. Consecutive words are separated by at least one cycle with `ser_frame` low.
- R7: While `readout_phase` is low, `ser_frame` and `rdo_done` stay low from the next readout clock edge on.
- R8: In the readout phase, `rdo_done` is high exactly when the token has passed the last pixel and no word is being shifted. On an empty matrix it rises in the second readout cycle.
- R9: Hits presented while `readout_phase` is high are ignored.
- R10: The first cell clock cycle with `readout_phase` low after a readout clears all hit flags. Hits presented in that cycle are ignored.
- R11: After reset, `ser_frame`, `ser_data` and `rdo_done` are low and no pixel holds a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cell | input | 1 | Cell clock for hit and stamp capture |
| clk_rdo | input | 1 | Readout clock for the token and serializer |
| rst | input | 1 | Synchronous active-high reset, both domains |
| readout_phase | input | 1 | 0 = detection, 1 = readout |
| hit_in | input | 256 | Discriminator line per pixel, bit index = row*16+column |
| stamp_in | input | 5 | Current timestamp value |
| ser_data | output | 1 | Serial word bit, MSB first |
| ser_frame | output | 1 | High while a word is being shifted |
| rdo_done | output | 1 | Matrix fully read in this readout phase |

## Verification
The hardest case to reach from the ports is a hit that arrives during the readout phase on a pixel the token has not yet reached. A wrongly accepted hit would be read out in that same pass. The stimulus therefore injects a hit on pixel 254 at the start of a readout whose expected stream still ends with pixel 255, and also drives a hit in the cycle that clears the flags.

Seeded random rounds scatter hits, including repeats on the same pixel, over random stamps. Directed rounds cover the corner pixels, a full row of adjacent hits, and an empty matrix.

// File: rtl/tpr_pkg.sv
package tpr_pkg;

    parameter int COL_BITS   = 4;
    parameter int ROW_BITS   = 4;
    parameter int STAMP_BITS = 5;

    localparam int COLS      = 1 << COL_BITS;
    localparam int ROWS      = 1 << ROW_BITS;
    localparam int PIXELS    = COLS * ROWS;
    localparam int WORD_BITS = COL_BITS + ROW_BITS + STAMP_BITS;
    localparam int CNT_BITS  = $clog2(WORD_BITS);

    typedef struct packed {
        logic [COL_BITS-1:0]   col;
        logic [ROW_BITS-1:0]   row;
        logic [STAMP_BITS-1:0] stamp;
    } rdo_word_t;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_SHIFT = 1'b1
    } seq_state_t;

    function automatic logic [COL_BITS-1:0] pix_col(input int unsigned idx);
        return idx[COL_BITS-1:0];
    endfunction

    function automatic logic [ROW_BITS-1:0] pix_row(input int unsigned idx);
        return idx[COL_BITS +: ROW_BITS];
    endfunction

endpackage

// File: rtl/tpr_pixel_cell.sv
module tpr_pixel_cell
    import tpr_pkg::*;
#(
    parameter int SW = STAMP_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear_i,
    input  logic          cap_en_i,
    input  logic          hit_i,
    input  logic [SW-1:0] stamp_i,
    output logic          flag_o,
    output logic [SW-1:0] stamp_o
);

    logic          flag_q;
    logic [SW-1:0] stamp_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            flag_q  <= 1'b0;
            stamp_q <= '0;
        end else if (cap_en_i && hit_i && !flag_q) begin
            flag_q  <= 1'b1;
            stamp_q <= stamp_i;
        end
    end

    assign flag_o  = flag_q;
    assign stamp_o = stamp_q;

    AST_STAMP_HELD: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clear_i) |=> (flag_q && $stable(stamp_q))); // R4

    AST_CLEAR_FLAG: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> !flag_q); // R10

endmodule

// File: rtl/tpr_token_chain.sv
module tpr_token_chain
    import tpr_pkg::*;
#(
    parameter int N  = PIXELS,
    parameter int SW = STAMP_BITS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run_i,
    input  logic [N-1:0]    pending_i,
    input  logic [SW-1:0]   stamps_i [N],
    output logic [N-1:0]    grant_o,
    output rdo_word_t       bus_o,
    output logic            tok_last_o
);

    // Token ripples from index 0; a pending cell absorbs it and drives the bus.
    always_comb begin
        logic carry;
        carry   = run_i;
        bus_o   = '0;
        grant_o = '0;
        for (int i = 0; i < N; i++) begin
            grant_o[i] = carry & pending_i[i];
            carry      = carry & ~pending_i[i];
            if (grant_o[i]) begin
                bus_o.col   = bus_o.col   | pix_col(i);
                bus_o.row   = bus_o.row   | pix_row(i);
                bus_o.stamp = bus_o.stamp | stamps_i[i];
            end
        end
        tok_last_o = carry;
    end

    AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o)); // R5

endmodule

// File: rtl/tpr_sequencer.sv
module tpr_sequencer
    import tpr_pkg::*;
#(
    parameter int N = PIXELS,
    parameter int W = WORD_BITS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         phase_i,
    input  logic [N-1:0] grant_i,
    input  rdo_word_t    bus_i,
    input  logic         tok_last_i,
    output logic         run_o,
    output logic [N-1:0] served_o,
    output logic         ser_data_o,
    output logic         ser_frame_o,
    output logic         done_o
);

    localparam logic [CNT_BITS-1:0] LAST = CNT_BITS'(W - 1);

    logic                phase_q;
    logic                entry;
    logic                last_bit;
    seq_state_t          state_q;
    logic [CNT_BITS-1:0] cnt_q;
    logic [W-1:0]        sreg_q;
    logic [N-1:0]        served_q;

    assign run_o    = phase_i & phase_q;
    assign entry    = phase_i & ~phase_q;
    assign last_bit = run_o && (state_q == SEQ_SHIFT) && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) phase_q <= 1'b0;
        else     phase_q <= phase_i;
    end

    always_ff @(posedge clk) begin
        if (rst || entry)  served_q <= '0;
        else if (last_bit) served_q <= served_q | grant_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            sreg_q  <= '0;
        end else if (!run_o) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (|grant_i) begin
                        sreg_q  <= bus_i;
                        cnt_q   <= '0;
                        state_q <= SEQ_SHIFT;
                    end
                end
                SEQ_SHIFT: begin
                    if (cnt_q == LAST) begin
                        state_q <= SEQ_IDLE;
                    end else begin
                        cnt_q  <= cnt_q + 1'b1;
                        sreg_q <= {sreg_q[W-2:0], 1'b0};
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign served_o    = served_q;
    assign ser_frame_o = (state_q == SEQ_SHIFT);
    assign ser_data_o  = (state_q == SEQ_SHIFT) ? sreg_q[W-1] : 1'b0;
    assign done_o      = run_o && (state_q == SEQ_IDLE) && tok_last_i;

    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (rst)
        (run_o && state_q == SEQ_SHIFT && cnt_q != LAST)
        |=> (!run_o || $stable(grant_i))); // R6

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!ser_frame_o && grant_i == '0)); // R8

endmodule

// File: rtl/token_pixel_readout.sv
module token_pixel_readout
    import tpr_pkg::*;
(
    input  logic                  clk_cell,
    input  logic                  clk_rdo,
    input  logic                  rst,
    input  logic                  readout_phase,
    input  logic [PIXELS-1:0]     hit_in,
    input  logic [STAMP_BITS-1:0] stamp_in,
    output logic                  ser_data,
    output logic                  ser_frame,
    output logic                  rdo_done
);

    logic                  cell_phase_q;
    logic                  clear_all;
    logic                  cap_en;
    logic [PIXELS-1:0]     flags;
    logic [STAMP_BITS-1:0] stamps [PIXELS];
    logic [PIXELS-1:0]     served;
    logic [PIXELS-1:0]     pending;
    logic [PIXELS-1:0]     grant;
    rdo_word_t             bus;
    logic                  tok_last;
    logic                  run;

    always_ff @(posedge clk_cell) begin
        if (rst) cell_phase_q <= 1'b0;
        else     cell_phase_q <= readout_phase;
    end

    assign clear_all = cell_phase_q & ~readout_phase;
    assign cap_en    = ~cell_phase_q & ~readout_phase;

    for (genvar g = 0; g < PIXELS; g++) begin : g_pix
        tpr_pixel_cell #(.SW(STAMP_BITS)) u_cell (
            .clk      (clk_cell),
            .rst      (rst),
            .clear_i  (clear_all),
            .cap_en_i (cap_en),
            .hit_i    (hit_in[g]),
            .stamp_i  (stamp_in),
            .flag_o   (flags[g]),
            .stamp_o  (stamps[g])
        );
    end

    assign pending = flags & ~served;

    tpr_token_chain #(.N(PIXELS), .SW(STAMP_BITS)) u_chain (
        .clk        (clk_rdo),
        .rst        (rst),
        .run_i      (run),
        .pending_i  (pending),
        .stamps_i   (stamps),
        .grant_o    (grant),
        .bus_o      (bus),
        .tok_last_o (tok_last)
    );

    tpr_sequencer #(.N(PIXELS), .W(WORD_BITS)) u_seq (
        .clk         (clk_rdo),
        .rst         (rst),
        .phase_i     (readout_phase),
        .grant_i     (grant),
        .bus_i       (bus),
        .tok_last_i  (tok_last),
        .run_o       (run),
        .served_o    (served),
        .ser_data_o  (ser_data),
        .ser_frame_o (ser_frame),
        .done_o      (rdo_done)
    );

    AST_QUIET_DETECT: assert property (@(posedge clk_rdo) disable iff (rst)
        !readout_phase |=> (!ser_frame && !rdo_done)); // R7

    AST_NO_CAPTURE_READOUT: assert property (@(posedge clk_cell) disable iff (rst)
        (readout_phase && cell_phase_q) |=> $stable(flags)); // R9

endmodule

// File: tb/token_pixel_readout_tb.sv
module token_pixel_readout_tb;
    import tpr_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                  rst;
    logic                  readout_phase;
    logic [PIXELS-1:0]     hit_in;
    logic [STAMP_BITS-1:0] stamp_in;
    logic                  ser_data, ser_frame, rdo_done;

    int checks = 0;
    int fails  = 0;

    bit                    exp_flag  [PIXELS];
    logic [STAMP_BITS-1:0] exp_stamp [PIXELS];

    token_pixel_readout u_dut (
        .clk_cell      (clk),
        .clk_rdo       (clk),
        .rst           (rst),
        .readout_phase (readout_phase),
        .hit_in        (hit_in),
        .stamp_in      (stamp_in),
        .ser_data      (ser_data),
        .ser_frame     (ser_frame),
        .rdo_done      (rdo_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [WORD_BITS-1:0] exp_word(input int idx);
        return {pix_col(idx), pix_row(idx), exp_stamp[idx]};
    endfunction

    task automatic model_clear();
        for (int i = 0; i < PIXELS; i++) begin
            exp_flag[i]  = 1'b0;
            exp_stamp[i] = '0;
        end
    endtask

    // Drive one hit pulse during detection; R7 quiet check in the same cycle.
    task automatic hit(input int idx, input int st);
        @(negedge clk);
        hit_in      = '0;
        hit_in[idx] = 1'b1;
        stamp_in    = STAMP_BITS'(st);
        if (!exp_flag[idx]) begin
            exp_flag[idx]  = 1'b1;
            exp_stamp[idx] = STAMP_BITS'(st);
        end
        @(negedge clk);
        hit_in = '0;
        chk(!ser_frame && !rdo_done, "R7", "activity in detection",
            {ser_frame, rdo_done}, 0);
    endtask

    task automatic run_readout(input string tag, input int inject);
        logic [WORD_BITS-1:0] expq [$];
        logic [WORD_BITS-1:0] cur;
        int nw, bc;
        bit fin;
        for (int i = 0; i < PIXELS; i++)
            if (exp_flag[i]) expq.push_back(exp_word(i));
        cur = '0; nw = 0; bc = 0; fin = 1'b0;
        @(negedge clk);
        readout_phase = 1'b1;
        for (int c = 0; c < 6000 && !fin; c++) begin
            if (c == 0 && inject >= 0) hit_in[inject] = 1'b1;
            @(negedge clk);
            hit_in = '0;
            if (ser_frame) begin
                chk(!rdo_done, "R8", {tag, " done during word"}, rdo_done, 0);
                cur = {cur[WORD_BITS-2:0], ser_data};
                bc++;
                if (bc == WORD_BITS) begin
                    if (nw < expq.size())
                        chk(cur == expq[nw], "R1 R2 R3", {tag, " word"},
                            int'(cur), int'(expq[nw]));
                    else
                        chk(1'b0, "R1 R9", {tag, " extra word"}, int'(cur), 0);
                    nw++;
                    bc = 0;
                end
            end else begin
                if (bc != 0)
                    chk(1'b0, "R2 R6", {tag, " frame broken"}, bc, WORD_BITS);
                bc = 0;
                if (rdo_done) fin = 1'b1;
            end
        end
        chk(fin, "R8", {tag, " done reached"}, fin, 1);
        chk(nw == expq.size(), "R1", {tag, " word count"}, nw, expq.size());
        @(negedge clk);
        readout_phase = 1'b0;
        model_clear();
        @(negedge clk);
        chk(!ser_frame && !rdo_done, "R7", {tag, " quiet after phase drop"},
            {ser_frame, rdo_done}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h1F2E);
        rst = 1'b1; readout_phase = 1'b0; hit_in = '0; stamp_in = '0;
        model_clear();
        repeat (3) @(negedge clk);
        chk(!ser_frame && !ser_data && !rdo_done, "R11", "reset outputs",
            {ser_frame, ser_data, rdo_done}, 0);
        rst = 1'b0;
        @(negedge clk);

        // R11: nothing held after reset -> empty readout, done only
        run_readout("R11 empty after reset", -1);

        // R1 R3 R4 R9: corners, repeat hit, hit injected during readout
        hit(0, 1);
        hit(255, 30);
        hit(17, 7);
        hit(17, 20);      // R4: ignored, stamp 7 kept
        run_readout("R4 R9 directed", 254);

        // R10: hit in the clearing cycle is ignored; prior flags gone
        @(negedge clk);
        readout_phase = 1'b1;
        @(negedge clk);
        @(negedge clk);
        readout_phase = 1'b0;
        hit_in[5] = 1'b1;
        @(negedge clk);
        hit_in = '0;
        run_readout("R10 clear cycle", -1);

        // R6: full row of adjacent hits, back-to-back tokens
        for (int c = 0; c < COLS; c++) hit(3 * COLS + c, c + 2);
        run_readout("R6 full row", -1);

        // Random rounds
        for (int r = 0; r < 6; r++) begin
            int n;
            n = 1 + int'($urandom % 20);
            for (int k = 0; k < n; k++)
                hit(int'($urandom % PIXELS), int'($urandom % (1 << STAMP_BITS)));
            run_readout("R1 R2 random", -1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule